// File: doc/BRIEF.md
# Tagged Operand Fetch Unit

This block performs the two operand-access operations of a tagged, stack-oriented processor: fetching a value for the top of stack and forming a reference to a variable. A request carries a 14-bit address couple. The couple is turned into a physical word address using a small table of lexical-level base registers plus an offset. Each memory word holds 48 data bits and a 3-bit type tag. What the unit does after a read depends on the tag of the word it reads.

A value fetch delivers a data word as soon as it reaches one. When it reads an indirect reference, it follows the couple that the reference holds, and it keeps doing so through any chain of references. When it reads a double-precision word, it also reads the next word. When it reads a procedure control word, it asks the surrounding processor to run the procedure and waits until a return value comes back. A reference request reads no memory. It returns the couple itself as a reference word. Only one request is in progress at a time. Each request ends with a one-cycle completion pulse and a fault code.

Top module: `opf_top`

## Requirements
- R1: After reset, `busy`, `done`, `proc_req` and `mem_rd_en` are all 0.
- R2: A request with `req_is_name`=1 reads no memory. It raises `done` on the cycle after the request is accepted, with `res_tag`=1, `res_a` equal to the couple zero-extended, `res_x`=0 and `fault`=0.
- R3: The physical address is the base register selected by couple bits [13:10] plus couple bits [9:0]. A base register takes the value of `base_wr_val` on a clock edge where `base_wr_en` is 1 and `base_wr_lex` selects it. Reset clears every base register to 0.
- R4: A value fetch that reads a word with tag 0 completes with `res_tag`=0, `res_a` equal to that word's data bits, `res_x`=0 and `fault`=0.
- R5: A word with tag 1 is an indirect reference. Its data bits [13:0] are a couple, which the unit translates and reads next.
- R6: A word with tag 2 at physical address p makes the unit also read p+1. The fetch completes with `res_tag`=2, `res_a` equal to the data at p and `res_x` equal to the data at p+1.
- R7: A word with tag 7 makes the unit hold `proc_req` high, with `proc_word` equal to that word's data, until `proc_ret` is 1. The fetch then completes with `res_tag`=0 and `res_a` equal to `proc_ret_value`. No completion happens before that point.
- R8: A word with tag 3, 4, 5 or 6 ends the fetch with `done` and `fault`=1. `fault` is 0 on every cycle where `done` is 0.
- R9: A chain of up to MAX_CHAIN indirect references (default 16) is followed. Reading one more reference ends the fetch with `fault`=2.
- R10: `busy` is high from the cycle after a value fetch is accepted until its completion cycle, in which it is low. A request presented while `busy` is high is ignored. Memory reads occur only while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted when not busy |
| req_is_name | input | 1 | 1 = reference request, 0 = value fetch |
| req_couple | input | 14 | Address couple (level in [13:10], offset in [9:0]) |
| base_wr_en | input | 1 | Base register write enable |
| base_wr_lex | input | 4 | Base register index |
| base_wr_val | input | AW | Base register value |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | AW | Memory read address |
| mem_rd_data | input | DATA_W+3 | Word returned one cycle after the strobe, tag in the top 3 bits |
| proc_req | output | 1 | Procedure entry requested |
| proc_word | output | DATA_W | Data bits of the procedure control word |
| proc_ret | input | 1 | Procedure has returned |
| proc_ret_value | input | DATA_W | Value returned by the procedure |
| busy | output | 1 | A value fetch is in progress |
| done | output | 1 | One-cycle completion pulse |
| res_tag | output | 3 | Tag of the result |
| res_a | output | DATA_W | Result word (top of stack) |
| res_x | output | DATA_W | Extension word for double precision |
| fault | output | 2 | 0 none, 1 invalid tag, 2 reference chain too long |

## Verification
The assertions assume that the memory returns the addressed word exactly one cycle after `mem_rd_en`. They also assume that `proc_ret` matters only while `proc_req` is high. The bench memory model reads on the clock edge where the strobe is high and presents the word in the following cycle. The bench pulses `proc_ret` only after it has seen `proc_req`. Base registers are rewritten only between requests, so each expected address follows from the table contents that were loaded before that request.

// File: rtl/opf_pkg.sv
package opf_pkg;
   localparam int COUPLE_W = 14;
   localparam int LEX_W    = 4;
   localparam int OFF_W    = 10;
   localparam int TAG_W    = 3;

   localparam logic [TAG_W-1:0] TAG_SP  = 3'd0;
   localparam logic [TAG_W-1:0] TAG_IND = 3'd1;
   localparam logic [TAG_W-1:0] TAG_DP  = 3'd2;
   localparam logic [TAG_W-1:0] TAG_PCW = 3'd7;

   localparam logic [1:0] FLT_NONE = 2'd0;
   localparam logic [1:0] FLT_TAG  = 2'd1;
   localparam logic [1:0] FLT_LOOP = 2'd2;

   typedef enum logic [2:0] {
      S_IDLE, S_RD, S_EVAL, S_RD2, S_EVAL2, S_PROC
   } opf_state_e;
endpackage

// File: rtl/opf_base_table.sv
module opf_base_table
   import opf_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [LEX_W-1:0]    wr_lex,
   input  logic [AW-1:0]       wr_val,
   input  logic [COUPLE_W-1:0] couple,
   output logic [AW-1:0]       phys
);
   localparam int ENTRIES = 1 << LEX_W;

   logic [AW-1:0] base_q [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            base_q[i] <= '0;
         else if (wr_en && (wr_lex == LEX_W'(i)))
            base_q[i] <= wr_val;
      end
   end

   always_comb
      phys = base_q[couple[COUPLE_W-1:OFF_W]]
           + {{(AW-OFF_W){1'b0}}, couple[OFF_W-1:0]};
endmodule

// File: rtl/opf_chain_guard.sv
module opf_chain_guard #(
   parameter int MAX_CHAIN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic full
);
   localparam int CW = $clog2(MAX_CHAIN + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr)
         cnt_q <= '0;
      else if (inc && !full)
         cnt_q <= cnt_q + CW'(1);
   end

   assign full = (cnt_q == CW'(MAX_CHAIN));
endmodule

// File: rtl/opf_sequencer.sv
module opf_sequencer
   import opf_pkg::*;
#(
   parameter int DATA_W = 48,
   parameter int AW     = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic                    req_is_name,
   input  logic [COUPLE_W-1:0]     req_couple,
   output logic [COUPLE_W-1:0]     xl_couple,
   input  logic [AW-1:0]           xl_phys,
   output logic                    chain_clr,
   output logic                    chain_inc,
   input  logic                    chain_full,
   output logic                    mem_rd_en,
   output logic [AW-1:0]           mem_rd_addr,
   input  logic [DATA_W+TAG_W-1:0] mem_rd_data,
   output logic                    proc_req,
   output logic [DATA_W-1:0]       proc_word,
   input  logic                    proc_ret,
   input  logic [DATA_W-1:0]       proc_ret_value,
   output logic                    busy,
   output logic                    done,
   output logic [TAG_W-1:0]        res_tag,
   output logic [DATA_W-1:0]       res_a,
   output logic [DATA_W-1:0]       res_x,
   output logic [1:0]              fault
);
   opf_state_e        state_q;
   logic [AW-1:0]     addr_q;
   logic [DATA_W-1:0] word_q;
   logic [TAG_W-1:0]  rd_tag;
   logic [DATA_W-1:0] rd_val;
   logic              accept;

   assign rd_tag = mem_rd_data[DATA_W+TAG_W-1:DATA_W];
   assign rd_val = mem_rd_data[DATA_W-1:0];
   assign accept = (state_q == S_IDLE) && req_valid;

   always_comb begin
      xl_couple = (state_q == S_IDLE) ? req_couple : rd_val[COUPLE_W-1:0];
      chain_clr = accept;
      chain_inc = (state_q == S_EVAL) && (rd_tag == TAG_IND) && !chain_full;
      mem_rd_en = (state_q == S_RD) || (state_q == S_RD2);
      mem_rd_addr = addr_q;
      proc_req  = (state_q == S_PROC);
      proc_word = word_q;
      busy      = (state_q != S_IDLE);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         addr_q  <= '0;
         word_q  <= '0;
         done    <= 1'b0;
         fault   <= FLT_NONE;
         res_tag <= TAG_SP;
         res_a   <= '0;
         res_x   <= '0;
      end else begin
         done  <= 1'b0;
         fault <= FLT_NONE;
         unique case (state_q)
            S_IDLE: begin
               if (req_valid) begin
                  if (req_is_name) begin
                     res_tag <= TAG_IND;
                     res_a   <= DATA_W'(req_couple);
                     res_x   <= '0;
                     done    <= 1'b1;
                  end else begin
                     addr_q  <= xl_phys;
                     state_q <= S_RD;
                  end
               end
            end
            S_RD:  state_q <= S_EVAL;
            S_RD2: state_q <= S_EVAL2;
            S_EVAL: begin
               case (rd_tag)
                  TAG_SP: begin
                     res_tag <= TAG_SP;
                     res_a   <= rd_val;
                     res_x   <= '0;
                     done    <= 1'b1;
                     state_q <= S_IDLE;
                  end
                  TAG_IND: begin
                     if (chain_full) begin
                        fault   <= FLT_LOOP;
                        done    <= 1'b1;
                        state_q <= S_IDLE;
                     end else begin
                        addr_q  <= xl_phys;
                        state_q <= S_RD;
                     end
                  end
                  TAG_DP: begin
                     res_a   <= rd_val;
                     addr_q  <= addr_q + AW'(1);
                     state_q <= S_RD2;
                  end
                  TAG_PCW: begin
                     word_q  <= rd_val;
                     state_q <= S_PROC;
                  end
                  default: begin
                     fault   <= FLT_TAG;
                     done    <= 1'b1;
                     state_q <= S_IDLE;
                  end
               endcase
            end
            S_EVAL2: begin
               res_x   <= rd_val;
               res_tag <= TAG_DP;
               done    <= 1'b1;
               state_q <= S_IDLE;
            end
            S_PROC: begin
               if (proc_ret) begin
                  res_tag <= TAG_SP;
                  res_a   <= proc_ret_value;
                  res_x   <= '0;
                  done    <= 1'b1;
                  state_q <= S_IDLE;
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/opf_top.sv
module opf_top
   import opf_pkg::*;
#(
   parameter int DATA_W    = 48,
   parameter int AW        = 16,
   parameter int MAX_CHAIN = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_is_name,
   input  logic [13:0]         req_couple,
   input  logic                base_wr_en,
   input  logic [3:0]          base_wr_lex,
   input  logic [AW-1:0]       base_wr_val,
   output logic                mem_rd_en,
   output logic [AW-1:0]       mem_rd_addr,
   input  logic [DATA_W+2:0]   mem_rd_data,
   output logic                proc_req,
   output logic [DATA_W-1:0]   proc_word,
   input  logic                proc_ret,
   input  logic [DATA_W-1:0]   proc_ret_value,
   output logic                busy,
   output logic                done,
   output logic [2:0]          res_tag,
   output logic [DATA_W-1:0]   res_a,
   output logic [DATA_W-1:0]   res_x,
   output logic [1:0]          fault
);
   if (AW < OFF_W) begin : g_bad_aw
      $error("opf_top: AW must cover the couple offset");
   end
   if (DATA_W < COUPLE_W) begin : g_bad_dw
      $error("opf_top: DATA_W must hold a couple");
   end
   if (MAX_CHAIN < 1) begin : g_bad_chain
      $error("opf_top: MAX_CHAIN must be at least 1");
   end

   logic [COUPLE_W-1:0] xl_couple;
   logic [AW-1:0]       xl_phys;
   logic                chain_clr;
   logic                chain_inc;
   logic                chain_full;

   opf_base_table #(.AW(AW)) u_base (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (base_wr_en),
      .wr_lex (base_wr_lex),
      .wr_val (base_wr_val),
      .couple (xl_couple),
      .phys   (xl_phys)
   );

   opf_chain_guard #(.MAX_CHAIN(MAX_CHAIN)) u_guard (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (chain_clr),
      .inc   (chain_inc),
      .full  (chain_full)
   );

   opf_sequencer #(.DATA_W(DATA_W), .AW(AW)) u_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .req_valid      (req_valid),
      .req_is_name    (req_is_name),
      .req_couple     (req_couple),
      .xl_couple      (xl_couple),
      .xl_phys        (xl_phys),
      .chain_clr      (chain_clr),
      .chain_inc      (chain_inc),
      .chain_full     (chain_full),
      .mem_rd_en      (mem_rd_en),
      .mem_rd_addr    (mem_rd_addr),
      .mem_rd_data    (mem_rd_data),
      .proc_req       (proc_req),
      .proc_word      (proc_word),
      .proc_ret       (proc_ret),
      .proc_ret_value (proc_ret_value),
      .busy           (busy),
      .done           (done),
      .res_tag        (res_tag),
      .res_a          (res_a),
      .res_x          (res_x),
      .fault          (fault)
   );
endmodule

// File: rtl/opf_checks.sv
module opf_checks #(
   parameter int DATA_W = 48
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_rd_en,
   input logic              proc_req,
   input logic [DATA_W-1:0] proc_word,
   input logic              proc_ret,
   input logic              busy,
   input logic              done,
   input logic [2:0]        res_tag,
   input logic [1:0]        fault
);
   assert_read_in_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rd_en |-> busy);

   assert_done_frees_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   assert_proc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (proc_req && !proc_ret) |=> (proc_req && $stable(proc_word)));

   assert_proc_no_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      proc_req |-> (busy && !done));

   assert_fault_only_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault != 2'd0) |-> done);

   assert_good_tag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && fault == 2'd0) |-> (res_tag == 3'd0 || res_tag == 3'd1 || res_tag == 3'd2));
endmodule

bind opf_top opf_checks #(.DATA_W(DATA_W)) u_opf_checks (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_rd_en (mem_rd_en),
   .proc_req  (proc_req),
   .proc_word (proc_word),
   .proc_ret  (proc_ret),
   .busy      (busy),
   .done      (done),
   .res_tag   (res_tag),
   .fault     (fault)
);

// File: tb/tb_opf_top.sv
module tb_opf_top;
   localparam int DW = 48;
   localparam int AW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_is_name = 1'b0;
   logic [13:0]   req_couple = '0;
   logic          base_wr_en = 1'b0;
   logic [3:0]    base_wr_lex = '0;
   logic [AW-1:0] base_wr_val = '0;
   logic          mem_rd_en;
   logic [AW-1:0] mem_rd_addr;
   logic [DW+2:0] mem_rd_data = '0;
   logic          proc_req;
   logic [DW-1:0] proc_word;
   logic          proc_ret = 1'b0;
   logic [DW-1:0] proc_ret_value = '0;
   logic          busy, done;
   logic [2:0]    res_tag;
   logic [DW-1:0] res_a, res_x;
   logic [1:0]    fault;

   int checks = 0;
   int errors = 0;
   int reads  = 0;
   int dones  = 0;
   int cycles = 0;
   logic [DW+2:0] mem [1024];

   always #5 clk = ~clk;

   opf_top dut (.*);

   always @(posedge clk) begin
      if (mem_rd_en) begin
         mem_rd_data <= mem[mem_rd_addr[9:0]];
         reads <= reads + 1;
      end
      if (done) dones <= dones + 1;
   end

   task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", rq, act, exp);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

   task automatic wr_base(input logic [3:0] lex, input logic [AW-1:0] v);
      @(negedge clk);
      base_wr_en = 1'b1; base_wr_lex = lex; base_wr_val = v;
      @(negedge clk);
      base_wr_en = 1'b0;
   endtask

   // issue a request, return number of negedges until done was seen
   task automatic run(input logic nm, input logic [13:0] cpl, output int lat);
      @(negedge clk);
      req_valid = 1'b1; req_is_name = nm; req_couple = cpl;
      lat = 0;
      for (int i = 0; i < 200; i++) begin
         @(negedge clk);
         req_valid = 1'b0;
         lat++;
         if (done) break;
      end
   endtask

   function automatic logic [DW+2:0] w(input logic [2:0] t, input logic [DW-1:0] d);
      return {t, d};
   endfunction

   typedef struct packed {
      logic        nm;
      logic [13:0] cpl;
      logic [2:0]  tag;
      logic [47:0] a;
      logic [47:0] x;
      logic [1:0]  flt;
      logic [7:0]  rq;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VEC [NV] = '{
      '{1'b1, 14'h2ABC, 3'd1, 48'h2ABC, 48'h0, 2'd0, 8'd2},                   // R2 name
      '{1'b0, 14'h0005, 3'd0, 48'h123456789ABC, 48'h0, 2'd0, 8'd4},           // R4 data
      '{1'b0, {4'd1, 10'd7}, 3'd0, 48'hAAAA00005555, 48'h0, 2'd0, 8'd3},      // R3 base 1
      '{1'b0, 14'd10, 3'd0, 48'h0000DEADBEEF, 48'h0, 2'd0, 8'd5},             // R5 one hop
      '{1'b0, 14'd11, 3'd2, 48'h111111111111, 48'h222222222222, 2'd0, 8'd6},  // R6 via chain
      '{1'b0, 14'd13, 3'd0, 48'h0, 48'h0, 2'd1, 8'd8},                        // R8 tag 3
      '{1'b0, 14'd14, 3'd0, 48'h0, 48'h0, 2'd1, 8'd8},                        // R8 tag 6
      '{1'b0, 14'd500, 3'd0, 48'h00000000F00D, 48'h0, 2'd0, 8'd9},            // R9 exactly 16
      '{1'b0, 14'd499, 3'd0, 48'h0, 48'h0, 2'd2, 8'd9},                       // R9 17 refs
      '{1'b0, 14'd600, 3'd0, 48'h0, 48'h0, 2'd2, 8'd9}                        // R9 self loop
   };

   initial begin
      int lat, r0, d0;
      string rq;
      for (int i = 0; i < 1024; i++) mem[i] = w(3'd0, 48'h0);
      mem[5]   = w(3'd0, 48'h123456789ABC);
      mem[107] = w(3'd0, 48'hAAAA00005555);
      mem[207] = w(3'd0, 48'h00000000BEE5);
      mem[10]  = w(3'd1, 48'(14'({4'd1, 10'd20})));
      mem[120] = w(3'd0, 48'h0000DEADBEEF);
      mem[11]  = w(3'd1, 48'd12);
      mem[12]  = w(3'd1, 48'(14'({4'd2, 10'd5})));
      mem[305] = w(3'd2, 48'h111111111111);
      mem[306] = w(3'd0, 48'h222222222222);
      mem[13]  = w(3'd3, 48'h1);
      mem[14]  = w(3'd6, 48'h1);
      mem[20]  = w(3'd7, 48'h000000000777);
      for (int k = 499; k < 516; k++) mem[k] = w(3'd1, 48'(k + 1));
      mem[516] = w(3'd0, 48'h00000000F00D);
      mem[600] = w(3'd1, 48'd600);

      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 busy", 48'(busy), 48'd0);
      chk("R1 done", 48'(done), 48'd0);
      chk("R1 proc_req", 48'(proc_req), 48'd0);
      chk("R1 mem_rd_en", 48'(mem_rd_en), 48'd0);
      rst_n = 1'b1;

      wr_base(4'd1, 16'd100);
      wr_base(4'd2, 16'd300);

      for (int v = 0; v < NV; v++) begin
         r0 = reads;
         run(VEC[v].nm, VEC[v].cpl, lat);
         rq = $sformatf("R%0d vec%0d", VEC[v].rq, v);
         chk({rq, " done"}, 48'(done), 48'd1);
         chk({rq, " fault"}, 48'(fault), 48'(VEC[v].flt));
         if (VEC[v].flt == 2'd0) begin
            chk({rq, " tag"}, 48'(res_tag), 48'(VEC[v].tag));
            chk({rq, " a"}, res_a, VEC[v].a);
            chk({rq, " x"}, res_x, VEC[v].x);
         end
         if (VEC[v].nm) begin
            chk("R2 latency", 48'(lat), 48'd1);
            chk("R2 no reads", 48'(reads - r0), 48'd0);
         end
         @(negedge clk);
         chk({rq, " fault clears R8"}, 48'(fault), 48'd0);
      end

      // R6 reads exactly two words
      r0 = reads;
      wr_base(4'd2, 16'd300);
      run(1'b0, {4'd2, 10'd5}, lat);
      chk("R6 two reads", 48'(reads - r0), 48'd2);

      // R3 rewrite base of level 1
      wr_base(4'd1, 16'd200);
      run(1'b0, {4'd1, 10'd7}, lat);
      chk("R3 new base", res_a, 48'h00000000BEE5);

      // R7 procedure entry
      @(negedge clk);
      req_valid = 1'b1; req_is_name = 1'b0; req_couple = 14'd20;
      @(negedge clk);
      req_valid = 1'b0;
      d0 = dones;
      for (int i = 0; i < 20 && !proc_req; i++) @(negedge clk);
      chk("R7 proc_req", 48'(proc_req), 48'd1);
      chk("R7 proc_word", proc_word, 48'h777);
      repeat (6) @(negedge clk);
      chk("R7 still waiting", 48'(proc_req), 48'd1);
      chk("R7 no early done", 48'(dones - d0), 48'd0);
      proc_ret = 1'b1; proc_ret_value = 48'h00000000CAFE;
      @(negedge clk);
      proc_ret = 1'b0;
      chk("R7 done", 48'(done), 48'd1);
      chk("R7 value", res_a, 48'h00000000CAFE);
      chk("R7 tag", 48'(res_tag), 48'd0);
      chk("R7 released", 48'(proc_req), 48'd0);

      // R10 request while busy is ignored
      @(negedge clk);
      d0 = dones;
      req_valid = 1'b1; req_is_name = 1'b0; req_couple = 14'd500;
      @(negedge clk);
      chk("R10 busy after accept", 48'(busy), 48'd1);
      req_is_name = 1'b1; req_couple = 14'h1111;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 200 && !done; i++) @(negedge clk);
      chk("R10 busy low at done", 48'(busy), 48'd0);
      chk("R10 first result kept", res_a, 48'h00000000F00D);
      repeat (4) @(negedge clk);
      chk("R10 single completion", 48'(dones - d0), 48'd1);

      // R1 reset mid-fetch
      @(negedge clk);
      req_valid = 1'b1; req_is_name = 1'b0; req_couple = 14'd600;
      @(negedge clk);
      req_valid = 1'b0;
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 busy after reset", 48'(busy), 48'd0);
      chk("R1 rd after reset", 48'(mem_rd_en), 48'd0);
      rst_n = 1'b1;

      summary();
   end
endmodule